// File: doc/BRIEF.md
# Split-Word Counter Read Port

This block lets a narrow bus read a wide free-running counter through two words. The low word holds the bottom bits of the count. The high word holds the remaining top bits, plus a busy flag in its most significant bit. The counter may be active (live and tracking) or asleep. While it is asleep, the port returns the last count it saw while the counter was active, and it flags that value as busy.

To read a coherent value, software reads the low word first and then the high word. At the low-word read, the port snapshots the upper bits and the busy state. The following high-word read returns that snapshot, so the two halves always belong to the same count. If the low word was read while the counter slept, the high word reports busy even if the counter has woken since. Software then retries the pair until busy reads clear. Each read strobe updates its data word one clock later, and the word holds until the next strobe of the same kind.

Top module: `split_cnt_rd_port`

## Requirements
- R1: After reset both read data words are zero.
- R2: A low-word strobe while active loads the low word with bits WORD_W-1:0 of the counter input sampled at that edge, visible one clock later.
- R3: While inactive, reads return the counter value sampled at the last clock edge where active was high (zero if none since reset).
- R4: The high word places bits CNT_W-1:WORD_W of the value snapshotted at the preceding low-word read in its bits CNT_W-WORD_W-1:0. Bits WORD_W-2:CNT_W-WORD_W read as zero.
- R5: High-word bit WORD_W-1 (busy) is 1 exactly when the preceding low-word read happened while inactive. A change of the active flag between the two reads does not alter it.
- R6: A high-word read with no unconsumed low-word read before it returns the current snapshot with busy set. Each low-word read is consumed by one high-word read.
- R7: A data word does not change in cycles without its own strobe.
- R8: When both strobes come in the same cycle, the high word is served from the snapshot taken before that cycle. The low read starts a new pending pair.
- R9: A retry loop (read the pair and repeat while busy) always yields the exact live count at the final low-word read, and successive results never decrease.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Live counter value |
| active_i | input | 1 | Counter is active and cnt_i is valid |
| rd_lo_i | input | 1 | Low-word read strobe |
| rd_hi_i | input | 1 | High-word read strobe |
| rdata_lo_o | output | WORD_W | Low read data word |
| rdata_hi_o | output | WORD_W | High read data word: busy in bit WORD_W-1, top count bits at the bottom |

## Verification
The bench builds the port with a 12-bit counter split into 8-bit words. This leaves four count bits in the high word and the busy flag at bit 7. At that size, every counter value is read as a pair, so each carry across the word boundary is covered. Sleep and wake transitions are placed between the two reads of a pair, and simultaneous strobes are checked. A long retry run with an irregular active pattern checks that each final value is exact and monotonic.

// File: rtl/split_cnt_pkg.sv
package split_cnt_pkg;
  parameter int CNT_W_DEF  = 52;
  parameter int WORD_W_DEF = 32;
endpackage

// File: rtl/cnt_hold_reg.sv
// Holds the last count seen while active; presents the visible value.
module cnt_hold_reg #(
  parameter int CNT_W = 52
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             active_i,
  output logic [CNT_W-1:0] vis_o
);
  logic [CNT_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_q <= '0;
    else if (active_i) last_q <= cnt_i;
  end

  assign vis_o = active_i ? cnt_i : last_q;

  a_r3_frozen_when_asleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> $stable(last_q));
endmodule

// File: rtl/lo_snap.sv
// Low-word read: returns low bits, snapshots upper bits and busy state.
module lo_snap #(
  parameter int CNT_W  = 52,
  parameter int WORD_W = 32,
  localparam int HI_W  = CNT_W - WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  vis_i,
  input  logic              active_i,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  output logic [WORD_W-1:0] rdata_lo_o,
  output logic [HI_W-1:0]   snap_hi_o,
  output logic              snap_busy_o,
  output logic              pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_lo_o  <= '0;
      snap_hi_o   <= '0;
      snap_busy_o <= 1'b1;
      pend_o      <= 1'b0;
    end else if (rd_lo_i) begin
      rdata_lo_o  <= vis_i[WORD_W-1:0];
      snap_hi_o   <= vis_i[CNT_W-1:WORD_W];
      snap_busy_o <= !active_i;
      pend_o      <= 1'b1;
    end else if (rd_hi_i) begin
      pend_o      <= 1'b0;
    end
  end

  a_r7_lo_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_lo_i |=> $stable(rdata_lo_o));
  a_r6_pair_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hi_i && !rd_lo_i |=> !pend_o);
endmodule

// File: rtl/hi_word.sv
// High-word read: top count bits plus busy flag in the top bit.
module hi_word #(
  parameter int CNT_W  = 52,
  parameter int WORD_W = 32,
  localparam int HI_W  = CNT_W - WORD_W,
  localparam int BUSY_BIT = WORD_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_hi_i,
  input  logic              pend_i,
  input  logic [HI_W-1:0]   snap_hi_i,
  input  logic              snap_busy_i,
  output logic [WORD_W-1:0] rdata_hi_o
);
  logic [WORD_W-1:0] word_d;

  always_comb begin
    word_d              = '0;
    word_d[HI_W-1:0]    = snap_hi_i;
    // an orphan high read is never trusted
    word_d[BUSY_BIT]    = pend_i ? snap_busy_i : 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_hi_o <= '0;
    else if (rd_hi_i) rdata_hi_o <= word_d;
  end

  a_r6_orphan_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hi_i && !pend_i |=> rdata_hi_o[BUSY_BIT]);
  a_r5_busy_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hi_i && pend_i && snap_busy_i |=> rdata_hi_o[BUSY_BIT]);
  a_r7_hi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hi_i |=> $stable(rdata_hi_o));
endmodule

// File: rtl/split_cnt_rd_port.sv
module split_cnt_rd_port #(
  parameter int CNT_W  = split_cnt_pkg::CNT_W_DEF,
  parameter int WORD_W = split_cnt_pkg::WORD_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              active_i,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  output logic [WORD_W-1:0] rdata_lo_o,
  output logic [WORD_W-1:0] rdata_hi_o
);
  localparam int HI_W = CNT_W - WORD_W;

  logic [CNT_W-1:0] vis;
  logic [HI_W-1:0]  snap_hi;
  logic             snap_busy;
  logic             pend;

  cnt_hold_reg #(.CNT_W(CNT_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt_i), .active_i(active_i), .vis_o(vis)
  );

  lo_snap #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_lo (
    .clk_i(clk_i), .rst_ni(rst_ni), .vis_i(vis), .active_i(active_i),
    .rd_lo_i(rd_lo_i), .rd_hi_i(rd_hi_i), .rdata_lo_o(rdata_lo_o),
    .snap_hi_o(snap_hi), .snap_busy_o(snap_busy), .pend_o(pend)
  );

  hi_word #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_hi_i(rd_hi_i), .pend_i(pend),
    .snap_hi_i(snap_hi), .snap_busy_i(snap_busy), .rdata_hi_o(rdata_hi_o)
  );

  a_r2_live_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i && active_i |=> rdata_lo_o == $past(cnt_i[WORD_W-1:0]));
endmodule

// File: tb/split_cnt_rd_port_test.sv
module split_cnt_rd_port_test;
  localparam int CNT_W  = 12;
  localparam int WORD_W = 8;
  localparam int HI_W   = CNT_W - WORD_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] cnt = '0;
  logic act = 1'b0, rd_lo = 1'b0, rd_hi = 1'b0;
  logic [WORD_W-1:0] lo_w, hi_w;
  logic [CNT_W-1:0] hold_m = '0;
  logic run = 1'b0;
  logic [7:0] lfsr = 8'h5a;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  split_cnt_rd_port #(.CNT_W(CNT_W), .WORD_W(WORD_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .active_i(act),
    .rd_lo_i(rd_lo), .rd_hi_i(rd_hi), .rdata_lo_o(lo_w), .rdata_hi_o(hi_w)
  );

  function automatic logic [WORD_W-1:0] mk_hi(logic [HI_W-1:0] up, logic busy);
    logic [WORD_W-1:0] w;
    w = '0; w[HI_W-1:0] = up; w[WORD_W-1] = busy;
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (act) hold_m = cnt;
    @(negedge clk);
    if (run) begin
      cnt = cnt + 1'b1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      act = |lfsr[1:0];
    end
  endtask

  task automatic rd_lo_op(output logic [CNT_W-1:0] vis);
    vis = act ? cnt : hold_m;
    rd_lo = 1'b1; tick(); rd_lo = 1'b0;
  endtask

  task automatic rd_hi_op();
    rd_hi = 1'b1; tick(); rd_hi = 1'b0;
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: got hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] v, a, prev;
    logic [WORD_W-1:0] lo_s, hi_s;
    repeat (3) @(negedge clk);
    chk("R1 lo", lo_w, 0); chk("R1 hi", hi_w, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: orphan high read after reset
    rd_hi_op();
    chk("R6 orphan", hi_w, mk_hi(0, 1));

    // R2/R4/R5: exhaustive active sweep
    act = 1'b1;
    for (int i = 0; i < (1 << CNT_W); i++) begin
      cnt = CNT_W'(i);
      rd_lo_op(v);
      chk("R2 lo", lo_w, v[WORD_W-1:0]);
      rd_hi_op();
      chk("R4 hi", hi_w, mk_hi(v[CNT_W-1:WORD_W], 0));
    end

    // R3: frozen value while asleep
    for (int i = 0; i < 16; i++) begin
      act = 1'b1; cnt = CNT_W'(i * 251 + 7); a = cnt; tick();
      act = 1'b0; cnt = ~a;
      rd_lo_op(v);
      chk("R3 lo", lo_w, a[WORD_W-1:0]);
      rd_hi_op();
      chk("R3 hi", hi_w, mk_hi(a[CNT_W-1:WORD_W], 1));
    end

    // R5: busy latched at low read despite wake before high read
    act = 1'b1; cnt = 12'h3a5; tick(); act = 1'b0; cnt = 12'hc11;
    rd_lo_op(v);
    act = 1'b1; cnt = 12'hd22;
    rd_hi_op();
    chk("R5 asleep-then-wake", hi_w, mk_hi(4'h3, 1));
    // R5: active low read then sleep before high read
    cnt = 12'h7e1; rd_lo_op(v);
    act = 1'b0; cnt = 12'h111;
    rd_hi_op();
    chk("R5 active-then-sleep", hi_w, mk_hi(4'h7, 0));
    // R6: second high read is orphan
    act = 1'b1; cnt = 12'h9b0;
    rd_hi_op();
    chk("R6 consumed", hi_w, mk_hi(4'h7, 1));

    // R8: simultaneous strobes
    cnt = 12'h256; rd_lo_op(v);
    cnt = 12'hb4c; rd_lo = 1'b1; rd_hi = 1'b1; tick(); rd_lo = 1'b0; rd_hi = 1'b0;
    chk("R8 hi old", hi_w, mk_hi(4'h2, 0));
    chk("R8 lo new", lo_w, 8'h4c);
    rd_hi_op();
    chk("R8 hi new", hi_w, mk_hi(4'hb, 0));

    // R7: words hold without strobes
    lo_s = lo_w; hi_s = hi_w;
    for (int i = 0; i < 5; i++) begin cnt = cnt + 12'h1f3; act = ~act; tick(); end
    chk("R7 lo hold", lo_w, lo_s); chk("R7 hi hold", hi_w, hi_s);

    // R9: retry reads with irregular sleep pattern
    act = 1'b1; cnt = 12'hef0; tick(); prev = '0; run = 1'b1;
    for (int n = 0; n < 400; n++) begin
      logic [CNT_W-1:0] got;
      int tries = 0;
      do begin
        rd_lo_op(v); lo_s = lo_w;
        rd_hi_op(); hi_s = hi_w;
        tries++;
      end while (hi_s[WORD_W-1] && tries < 64);
      got = {hi_s[HI_W-1:0], lo_s};
      chk("R9 coherent", got, v);
      if (got < prev && !(prev > 12'hf00 && got < 12'h100)) chk("R9 monotonic", got, prev);
      prev = got;
      if (got > 12'hf80) begin run = 1'b0; act = 1'b1; cnt = '0; tick(); prev = '0; run = 1'b1; end
    end
    run = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule